// File: doc/BRIEF.md
# Dual Reloading Down-Counter Timer

This block holds two down-counting timers and one free-running debug tick counter behind a small 32-bit register bus. A shared `tick` input advances everything. Each timer decrements on a tick while its run bit is set. When a tick finds the timer at zero, it reloads and latches its own interrupt flag. The flag stays high until software writes that timer's clear register.

A mode bit in each timer's control register selects the wrap behaviour. In periodic mode the timer reloads from its load register. In free-running mode it reloads to the all-ones value of its own width. Timer 0 is 16 bits wide and timer 1 is 32 bits wide by default. The debug counter is 40 bits wide by default, counts every tick whether or not any timer runs, and is read as a low word and a high word. Reads have no side effects and return data in the same cycle as the address.

Top module: `dtmr_pair`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is asserted, the timer values, load registers, control registers, interrupt flags and debug counter return to zero, and `irq` is low.
- R2: A tick on a running timer whose value is nonzero lowers that value by exactly one and leaves its interrupt flag unchanged.
- R3: A tick on a running timer whose value is zero reloads it. With control bit 6 set, the new value is the load register. With bit 6 clear, it is all ones at the timer's width (0xFFFF for the 16-bit timer, 0xFFFFFFFF for the 32-bit timer).
- R4: Each reload sets that timer's interrupt flag. Timer 0's flag is bit 4 and timer 1's flag is bit 5 of the status word at address 0x50. `irq[i]` follows timer i's flag.
- R5: Any write to a timer's clear register (offset 0x0C) drops that timer's flag. If a reload of that timer falls in the same cycle, the flag stays set.
- R6: A timer changes its value only on a cycle where `tick` is high and its control bit 7 (run) is set.
- R7: Writes to the value register (offset 0x04) are ignored. The clear register reads as zero. Writing the load register does not change the current value.
- R8: The debug counter increments by one on every tick. Address 0x40 returns its lowest DBG_LO_W bits, and address 0x44 returns the bits above them.
- R9: Timer 0 sits at base 0x00 and timer 1 at base 0x20. Within a timer, the offsets are load 0x00, value 0x04, control 0x08 and clear 0x0C. The control register reads back only bits 7:6. The load register keeps only the timer's width. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse, one count per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 2 | Per-timer latched interrupt flags |

## Verification
The bench builds the block with timer 0 at 8 bits, timer 1 at its default 32 bits, a 40-bit debug counter and DBG_LO_W = 8. With the narrow timer 0, a full count from all ones down to zero and the periodic reload that follows take only a few hundred ticks. The narrow low word means the debug counter carries into its high word during the run. Keeping timer 1 at 32 bits still exercises the widest wrap to 0xFFFFFFFF.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int BUS_W = 32;

    typedef struct packed {
        logic run;
        logic periodic;
    } tctl_t;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_VALUE = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLR   = 2'd3
    } treg_e;

    localparam int CTL_PERIODIC_BIT = 6;
    localparam int CTL_RUN_BIT      = 7;
    localparam int IRQ_BIT0         = 4;

    localparam logic [7:0] T0_BASE     = 8'h00;
    localparam logic [7:0] T1_BASE     = 8'h20;
    localparam logic [7:0] DBG_LO_ADDR = 8'h40;
    localparam logic [7:0] DBG_HI_ADDR = 8'h44;
    localparam logic [7:0] STAT_ADDR   = 8'h50;

    function automatic logic timer_hit(input logic [7:0] a, input logic [7:0] base);
        return (a[7:4] == base[7:4]) && (a[1:0] == 2'b00);
    endfunction

    function automatic tctl_t ctl_from_bits(input logic run_b, input logic per_b);
        tctl_t c;
        c.run      = run_b;
        c.periodic = per_b;
        return c;
    endfunction

endpackage

// File: rtl/dtmr_chan.sv
module dtmr_chan
    import dtmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                wr_load,
    input  logic                wr_ctl,
    input  logic                wr_clr,
    input  logic [W-1:0]        load_in,
    input  tctl_t               ctl_in,
    output logic [BUS_W-1:0]    load_rd,
    output logic [BUS_W-1:0]    val_rd,
    output tctl_t               ctl_q,
    output logic                irq_q
);

    logic [W-1:0] load_q;
    logic [W-1:0] value_q;
    logic         step;
    logic         at_zero;
    logic [W-1:0] reload_val;

    assign step       = tick && ctl_q.run;
    assign at_zero    = (value_q == '0);
    assign reload_val = ctl_q.periodic ? load_q : {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q  <= '0;
            value_q <= '0;
            ctl_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (wr_load) load_q <= load_in;
            if (wr_ctl)  ctl_q  <= ctl_in;
            if (step)    value_q <= at_zero ? reload_val : value_q - 1'b1;
            if (step && at_zero) irq_q <= 1'b1;
            else if (wr_clr)     irq_q <= 1'b0;
        end
    end

    assign load_rd = BUS_W'(load_q);
    assign val_rd  = BUS_W'(value_q);

endmodule

// File: rtl/dtmr_dbg.sv
module dtmr_dbg #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/dtmr_pair.sv
module dtmr_pair
    import dtmr_pkg::*;
#(
    parameter int TMR0_W   = 16,
    parameter int TMR1_W   = 32,
    parameter int DBG_W    = 40,
    parameter int DBG_LO_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [1:0]  irq
);

    localparam int NCH = 2;
    localparam logic [DBG_W-1:0] LO_MASK = DBG_W'((64'd1 << DBG_LO_W) - 64'd1);

    logic [NCH-1:0]            t_hit;
    logic [NCH-1:0][BUS_W-1:0] chan_load;
    logic [NCH-1:0][BUS_W-1:0] chan_val;
    tctl_t [NCH-1:0]           chan_ctl;
    logic [NCH-1:0]            chan_en;
    logic [DBG_W-1:0]          dbg_cnt;
    treg_e                     reg_off;
    tctl_t                     ctl_wr;

    assign reg_off = treg_e'(bus_addr[3:2]);
    assign ctl_wr  = ctl_from_bits(bus_wdata[CTL_RUN_BIT], bus_wdata[CTL_PERIODIC_BIT]);

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam int         CW   = (i == 0) ? TMR0_W : TMR1_W;
        localparam logic [7:0] BASE = (i == 0) ? T0_BASE : T1_BASE;

        assign t_hit[i]   = timer_hit(bus_addr, BASE);
        assign chan_en[i] = chan_ctl[i].run;

        dtmr_chan #(.W(CW)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .wr_load (bus_wr && t_hit[i] && reg_off == REG_LOAD),
            .wr_ctl  (bus_wr && t_hit[i] && reg_off == REG_CTRL),
            .wr_clr  (bus_wr && t_hit[i] && reg_off == REG_CLR),
            .load_in (bus_wdata[CW-1:0]),
            .ctl_in  (ctl_wr),
            .load_rd (chan_load[i]),
            .val_rd  (chan_val[i]),
            .ctl_q   (chan_ctl[i]),
            .irq_q   (irq[i])
        );
    end

    dtmr_dbg #(.W(DBG_W)) u_dbg (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cnt_q (dbg_cnt)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (t_hit[i]) begin
                case (reg_off)
                    REG_LOAD:  bus_rdata = chan_load[i];
                    REG_VALUE: bus_rdata = chan_val[i];
                    REG_CTRL:  bus_rdata[CTL_RUN_BIT:CTL_PERIODIC_BIT] = chan_ctl[i];
                    default:   bus_rdata = '0;
                endcase
            end
        end
        if (bus_addr == DBG_LO_ADDR) bus_rdata = BUS_W'(dbg_cnt & LO_MASK);
        if (bus_addr == DBG_HI_ADDR) bus_rdata = BUS_W'(dbg_cnt >> DBG_LO_W);
        if (bus_addr == STAT_ADDR)   bus_rdata[IRQ_BIT0 +: NCH] = irq;
    end

endmodule

// File: rtl/dtmr_pair_chk.sv
module dtmr_pair_chk #(
    parameter int DBG_W = 40
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [1:0]       irq,
    input logic [1:0][31:0] chan_val,
    input logic [1:0]       chan_en,
    input logic [DBG_W-1:0] dbg_cnt
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (chan_val[0] == '0 && chan_val[1] == '0 && irq == 2'b00 && dbg_cnt == '0)); // R1

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && chan_en[0] && chan_val[0] != '0) |=> (chan_val[0] == $past(chan_val[0]) - 32'd1)); // R2

    AST_RELOAD_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tick && chan_en[1] && chan_val[1] == '0) |=> irq[1]); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(chan_val[0]) && $stable(chan_val[1]))); // R6

    AST_FLAG_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(irq[0]) |-> $past(bus_wr && bus_addr == 8'h0C)); // R5

    AST_DBG_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> (dbg_cnt == $past(dbg_cnt) + 1'b1)); // R8

endmodule

bind dtmr_pair dtmr_pair_chk #(.DBG_W(DBG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq      (irq),
    .chan_val (chan_val),
    .chan_en  (chan_en),
    .dbg_cnt  (dbg_cnt)
);

// File: tb/tb_dtmr_pair.sv
`timescale 1ns/1ps
module tb_dtmr_pair;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    int dbg_exp = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dtmr_pair #(.TMR0_W(8), .TMR1_W(32), .DBG_W(40), .DBG_LO_W(8)) dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        dbg_exp += n;
    endtask

    task automatic t_reset;
        rd_check(8'h00, 32'h0, "R1 load0");
        rd_check(8'h04, 32'h0, "R1 value0");
        rd_check(8'h08, 32'h0, "R1 ctrl0");
        rd_check(8'h24, 32'h0, "R1 value1");
        rd_check(8'h50, 32'h0, "R1 status");
        rd_check(8'h40, 32'h0, "R1 dbg");
        check(irq === 2'b00, "R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_free_wrap;
        wr(8'h08, 32'h80);
        ticks(1);
        rd_check(8'h04, 32'hFF, "R3 free wrap to all ones");
        check(irq[0] === 1'b1, "R4 irq0 set", 32'(irq), 32'h1);
        rd_check(8'h50, 32'h10, "R4 status bit4");
        ticks(3);
        rd_check(8'h04, 32'hFC, "R2 decrement");
    endtask

    task automatic t_clear;
        rd_check(8'h0C, 32'h0, "R7 clear reads zero");
        wr(8'h0C, 32'h0);
        check(irq[0] === 1'b0, "R5 clear drops irq0", 32'(irq), 32'h0);
        rd_check(8'h50, 32'h0, "R5 status cleared");
    endtask

    task automatic t_ignored_writes;
        wr(8'h04, 32'h12);
        rd_check(8'h04, 32'hFC, "R7 value write ignored");
        wr(8'h00, 32'h5);
        rd_check(8'h04, 32'hFC, "R7 load write keeps value");
        rd_check(8'h00, 32'h5, "R9 load readback");
        wr(8'h00, 32'h1A5);
        rd_check(8'h00, 32'hA5, "R9 load width truncation");
        wr(8'h00, 32'h3);
    endtask

    task automatic t_disabled;
        wr(8'h08, 32'h00);
        ticks(5);
        rd_check(8'h04, 32'hFC, "R6 stopped timer holds");
        rd_check(8'h40, 32'(dbg_exp & 8'hFF), "R8 dbg counts while timers stopped");
    endtask

    task automatic t_periodic;
        wr(8'h08, 32'hFF);
        rd_check(8'h08, 32'hC0, "R9 ctrl reads bits 7:6");
        ticks(252);
        rd_check(8'h04, 32'h0, "R2 count down to zero");
        check(irq[0] === 1'b0, "R2 no flag before reload", 32'(irq), 32'h0);
        rd_check(8'h40, 32'(dbg_exp % 256), "R8 dbg low after carry");
        rd_check(8'h44, 32'(dbg_exp / 256), "R8 dbg high after carry");
        ticks(1);
        rd_check(8'h04, 32'h3, "R3 periodic reload from load");
        check(irq[0] === 1'b1, "R4 periodic flag", 32'(irq), 32'h1);
        ticks(4);
        rd_check(8'h04, 32'h3, "R3 second periodic reload");
    endtask

    task automatic t_set_beats_clear;
        ticks(3);
        rd_check(8'h04, 32'h0, "R5 at zero before race");
        wr(8'h0C, 32'h0);
        check(irq[0] === 1'b0, "R5 cleared before race", 32'(irq), 32'h0);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        dbg_exp += 1;
        check(irq[0] === 1'b1, "R5 reload wins over clear", 32'(irq), 32'h1);
        rd_check(8'h04, 32'h3, "R3 reload during race");
    endtask

    task automatic t_wide_timer;
        wr(8'h28, 32'h80);
        ticks(1);
        rd_check(8'h24, 32'hFFFFFFFF, "R3 32-bit free wrap");
        check(irq[1] === 1'b1, "R4 irq1 set", 32'(irq), 32'h3);
        rd_check(8'h50, 32'h30, "R4 status bits 4 and 5");
        ticks(2);
        rd_check(8'h24, 32'hFFFFFFFD, "R2 32-bit decrement");
        wr(8'h2C, 32'hDEAD);
        check(irq === 2'b01, "R5 clear only timer1", 32'(irq), 32'h1);
    endtask

    task automatic t_map;
        rd_check(8'h40, 32'(dbg_exp % 256), "R8 dbg low final");
        rd_check(8'h44, 32'(dbg_exp / 256), "R8 dbg high final");
        rd_check(8'h60, 32'h0, "R9 unmapped reads zero");
        rd_check(8'h05, 32'h0, "R9 misaligned reads zero");
    endtask

    initial begin
        rst = 1'b1; tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_free_wrap();
        t_clear();
        t_ignored_writes();
        t_disabled();
        t_periodic();
        t_set_beats_clear();
        t_wide_timer();
        t_map();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule